// File: doc/BRIEF.md
# Accumulator Fetch-Execute Core

This block is a small processor built around one 16-bit accumulator. It repeats a fetch-execute cycle on 16-bit instruction words. Each word holds a 4-bit opcode in bits 15:12 and a 12-bit operand in bits 11:0. The operand is either a memory address or an I/O device number. Every register transfer takes its own clock cycle and goes through explicit registers:
- a program counter,
- a memory address register (MAR),
- a memory buffer register (MBR),
- an instruction register,
- the accumulator.

The core drives a synchronous single-port word memory of 4096 locations and a numbered I/O port. On the memory, a read issued in one cycle returns its data in the next cycle. On the I/O port, the read data must be valid in the same cycle as the read strobe.

The sequencer has these states:
- Fetch, four states. FETCH_ADDR copies the PC into the MAR. FETCH_READ issues the read and increments the PC. FETCH_CAPTURE loads the returned word into the MBR. FETCH_IR copies the MBR into the IR and decodes the opcode from that same word.
- Memory load and add. EXEC_ADDR moves the operand into the MAR. EXEC_READ issues the read. EXEC_CAPTURE fills the MBR. Then WB_LOAD copies the MBR into the AC, or WB_ADD writes AC+MBR into the AC.
- Store. EXEC_ADDR, then STORE_BUF copies the AC into the MBR, then STORE_WRITE writes the MBR to memory at the MAR.
- Input. IN_READ pulses the read strobe and captures the device data into the MBR. WB_LOAD follows.
- Output. OUT_BUF copies the AC into the MBR. OUT_WRITE pulses the write strobe.
- HALT is entered from FETCH_IR on any other opcode and left only by reset.

All execute paths return to FETCH_ADDR.

Top module: `acc_core`

## Requirements
- R1: After reset is released, the first memory read is at the start address parameter (default 0x300).
- R2: Instruction fetches read consecutive addresses. Each fetch read is followed by that instruction's own accesses before the next fetch.
- R3: Opcode 1 reads memory at the 12-bit operand and loads that word into the accumulator.
- R4: Opcode 2 writes the accumulator to memory at the operand address, with exactly one write strobe.
- R5: Opcode 5 reads memory at the operand and adds that word to the accumulator modulo 2^16. No carry is kept.
- R6: Opcode 3 asserts the I/O read strobe for exactly one cycle with the operand on the I/O address. The accumulator takes the I/O read data.
- R7: Opcode 7 asserts the I/O write strobe for exactly one cycle with the operand on the I/O address and the accumulator on the I/O write data.
- R8: Any other opcode raises `halted`. `halted` stays high until reset, and no memory or I/O strobe is asserted while it is high.
- R9: The memory read and write strobes are never asserted in the same cycle, and every memory access uses the address held in the MAR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 12 | Memory address (MAR) |
| mem_re | output | 1 | Memory read strobe; data valid the next cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data (MBR) |
| mem_rdata | input | 16 | Memory read data |
| io_addr | output | 12 | I/O device number |
| io_rd | output | 1 | I/O read strobe, one cycle |
| io_wr | output | 1 | I/O write strobe, one cycle |
| io_wdata | output | 16 | I/O write data |
| io_rdata | input | 16 | I/O read data, valid in the strobe cycle |
| halted | output | 1 | Sticky halt indication |

## Verification
The hardest cases to reach from the ports are add overflow and the check that a stored value really landed in memory. Add overflow needs the accumulator loaded with 0xFFFF first. The stored value can only be seen through a later load and output.

The stimulus is one program. It loads 0xFFFF, adds 3, and stores the wrapped result. Later it reloads an address written earlier in the same program and sends that value out on the I/O port. The program ends on an undefined opcode.

A scoreboard holds the expected order of every memory and I/O access. It therefore catches any strobe that appears after the halt.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OP_LOAD  = 4'd1;
    localparam logic [OPC_W-1:0] OP_STORE = 4'd2;
    localparam logic [OPC_W-1:0] OP_IN    = 4'd3;
    localparam logic [OPC_W-1:0] OP_ADD   = 4'd5;
    localparam logic [OPC_W-1:0] OP_OUT   = 4'd7;

    typedef enum logic [3:0] {
        FETCH_ADDR,
        FETCH_READ,
        FETCH_CAPTURE,
        FETCH_IR,
        EXEC_ADDR,
        EXEC_READ,
        EXEC_CAPTURE,
        WB_LOAD,
        WB_ADD,
        STORE_BUF,
        STORE_WRITE,
        IN_READ,
        OUT_BUF,
        OUT_WRITE,
        HALT
    } state_t;

    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_ir;
        logic pc_inc;
        logic mbr_from_mem;
        logic mbr_from_ac;
        logic mbr_from_io;
        logic ir_from_mbr;
        logic ac_from_mbr;
        logic ac_from_sum;
    } ctrl_t;

endpackage

// File: rtl/acc_seq.sv
module acc_seq
    import acc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] mbr_opc,
    input  logic [OPC_W-1:0] ir_opc,
    output ctrl_t            ctrl,
    output logic             mem_re,
    output logic             mem_we,
    output logic             io_rd,
    output logic             io_wr,
    output logic             halted
);

    state_t state, state_nxt;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= FETCH_ADDR;
        else        state <= state_nxt;
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            FETCH_ADDR:    state_nxt = FETCH_READ;
            FETCH_READ:    state_nxt = FETCH_CAPTURE;
            FETCH_CAPTURE: state_nxt = FETCH_IR;
            FETCH_IR: begin
                unique case (mbr_opc)
                    OP_LOAD, OP_ADD, OP_STORE: state_nxt = EXEC_ADDR;
                    OP_IN:                     state_nxt = IN_READ;
                    OP_OUT:                    state_nxt = OUT_BUF;
                    default:                   state_nxt = HALT;
                endcase
            end
            EXEC_ADDR:     state_nxt = (ir_opc == OP_STORE) ? STORE_BUF : EXEC_READ;
            EXEC_READ:     state_nxt = EXEC_CAPTURE;
            EXEC_CAPTURE:  state_nxt = (ir_opc == OP_ADD) ? WB_ADD : WB_LOAD;
            WB_LOAD:       state_nxt = FETCH_ADDR;
            WB_ADD:        state_nxt = FETCH_ADDR;
            STORE_BUF:     state_nxt = STORE_WRITE;
            STORE_WRITE:   state_nxt = FETCH_ADDR;
            IN_READ:       state_nxt = WB_LOAD;
            OUT_BUF:       state_nxt = OUT_WRITE;
            OUT_WRITE:     state_nxt = FETCH_ADDR;
            HALT:          state_nxt = HALT;
            default:       state_nxt = HALT;
        endcase
    end

    // Outputs
    always_comb begin
        ctrl   = '0;
        mem_re = 1'b0;
        mem_we = 1'b0;
        io_rd  = 1'b0;
        io_wr  = 1'b0;
        halted = 1'b0;
        unique case (state)
            FETCH_ADDR:    ctrl.mar_from_pc = 1'b1;
            FETCH_READ: begin
                mem_re      = 1'b1;
                ctrl.pc_inc = 1'b1;
            end
            FETCH_CAPTURE: ctrl.mbr_from_mem = 1'b1;
            FETCH_IR:      ctrl.ir_from_mbr  = 1'b1;
            EXEC_ADDR:     ctrl.mar_from_ir  = 1'b1;
            EXEC_READ:     mem_re = 1'b1;
            EXEC_CAPTURE:  ctrl.mbr_from_mem = 1'b1;
            WB_LOAD:       ctrl.ac_from_mbr  = 1'b1;
            WB_ADD:        ctrl.ac_from_sum  = 1'b1;
            STORE_BUF:     ctrl.mbr_from_ac  = 1'b1;
            STORE_WRITE:   mem_we = 1'b1;
            IN_READ: begin
                io_rd            = 1'b1;
                ctrl.mbr_from_io = 1'b1;
            end
            OUT_BUF:       ctrl.mbr_from_ac = 1'b1;
            OUT_WRITE:     io_wr = 1'b1;
            HALT:          halted = 1'b1;
            default:       halted = 1'b1;
        endcase
    end

    assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    assert_halt_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !(mem_re || mem_we || io_rd || io_wr));

    // R6, R7: I/O strobes last a single cycle
    assert_io_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd || io_wr) |=> !(io_rd || io_wr));

    assert_mem_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
    import acc_pkg::*;
#(
    parameter int              DATA_W     = 16,
    parameter int              ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] START_ADDR = 12'h300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_t             ctrl,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] io_rdata,
    output logic [ADDR_W-1:0] mar,
    output logic [DATA_W-1:0] mbr,
    output logic [DATA_W-1:0] ir,
    output logic [DATA_W-1:0] ac
);

    localparam int OPND_W = DATA_W - OPC_W;

    logic [ADDR_W-1:0] pc;
    logic [OPND_W-1:0] operand;

    assign operand = ir[OPND_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc  <= START_ADDR;
            mar <= '0;
            mbr <= '0;
            ir  <= '0;
            ac  <= '0;
        end else begin
            if (ctrl.mar_from_pc)      mar <= pc;
            else if (ctrl.mar_from_ir) mar <= operand[ADDR_W-1:0];

            if (ctrl.pc_inc) pc <= pc + 1'b1;

            if (ctrl.mbr_from_mem)     mbr <= mem_rdata;
            else if (ctrl.mbr_from_ac) mbr <= ac;
            else if (ctrl.mbr_from_io) mbr <= io_rdata;

            if (ctrl.ir_from_mbr) ir <= mbr;

            if (ctrl.ac_from_mbr)      ac <= mbr;
            else if (ctrl.ac_from_sum) ac <= ac + mbr;
        end
    end

    // R2: the PC changes only by a single increment
    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(pc) |-> (pc == $past(pc) + 1'b1));

endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
#(
    parameter int              DATA_W     = 16,
    parameter int              ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] START_ADDR = 12'h300
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] io_addr,
    output logic              io_rd,
    output logic              io_wr,
    output logic [DATA_W-1:0] io_wdata,
    input  logic [DATA_W-1:0] io_rdata,
    output logic              halted
);

    ctrl_t             ctrl;
    logic [ADDR_W-1:0] mar;
    logic [DATA_W-1:0] mbr;
    logic [DATA_W-1:0] ir;
    logic [DATA_W-1:0] ac;

    acc_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mbr_opc (mbr[DATA_W-1 -: OPC_W]),
        .ir_opc  (ir[DATA_W-1 -: OPC_W]),
        .ctrl    (ctrl),
        .mem_re  (mem_re),
        .mem_we  (mem_we),
        .io_rd   (io_rd),
        .io_wr   (io_wr),
        .halted  (halted)
    );

    acc_datapath #(
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W),
        .START_ADDR (START_ADDR)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl      (ctrl),
        .mem_rdata (mem_rdata),
        .io_rdata  (io_rdata),
        .mar       (mar),
        .mbr       (mbr),
        .ir        (ir),
        .ac        (ac)
    );

    assign mem_addr  = mar;
    assign mem_wdata = mbr;
    assign io_addr   = ir[ADDR_W-1:0];
    assign io_wdata  = mbr;

    assert_store_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata == ac));

    assert_out_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr |-> (io_wdata == ac));

endmodule

// File: tb/tb_acc_core.sv
module tb_acc_core;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic        mem_re, mem_we;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic [11:0] io_addr;
    logic        io_rd, io_wr;
    logic [15:0] io_wdata;
    logic [15:0] io_rdata;
    logic        halted;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_core dut (
        .clk(clk), .rst_n(rst_n),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .halted(halted)
    );

    // Memory model: one-cycle read latency
    logic [15:0] mem [int];
    always @(posedge clk) begin
        if (mem_re) mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 16'h0000;
        if (mem_we) mem[int'(mem_addr)] = mem_wdata;
    end

    // Device model: data depends on device number
    assign io_rdata = 16'hC000 | {4'h0, io_addr};

    // Scoreboard: kinds 0 mem read, 1 mem write, 2 io read, 3 io write
    typedef struct {
        int          kind;
        logic [11:0] addr;
        logic [15:0] data;
        string       tag;
    } ev_t;
    ev_t exp_q[$];

    task automatic push_ev(input int kind, input logic [11:0] addr,
                           input logic [15:0] data, input string tag);
        ev_t e;
        e.kind = kind; e.addr = addr; e.data = data; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    task automatic observe(input int kind, input logic [11:0] addr, input logic [15:0] data);
        ev_t e;
        if (exp_q.size() == 0) begin
            check(1'b0, "R8", "unexpected access kind", 32'(kind), 32'hFFFF_FFFF);
        end else begin
            e = exp_q.pop_front();
            check(e.kind == kind, e.tag, "access kind", 32'(kind), 32'(e.kind));
            check(e.addr == addr, e.tag, "address", {20'h0, addr}, {20'h0, e.addr});
            if (kind == 1 || kind == 3)
                check(e.data == data, e.tag, "data", {16'h0, data}, {16'h0, e.data});
        end
    endtask

    // Monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_re && mem_we)
                check(1'b0, "R9", "read and write together", 32'h1, 32'h0);
            if (mem_re) observe(0, mem_addr, 16'h0);
            if (mem_we) observe(1, mem_addr, mem_wdata);
            if (io_rd)  observe(2, io_addr, 16'h0);
            if (io_wr)  observe(3, io_addr, io_wdata);
        end
    end

    task automatic fetch(input logic [11:0] a, input string tag);
        push_ev(0, a, 16'h0, tag);
    endtask

    initial begin
        bit timeout = 1'b0;

        // Program at 0x300
        mem[12'h300] = 16'h1940;  // load [940]
        mem[12'h301] = 16'h5941;  // add [941]
        mem[12'h302] = 16'h2950;  // store [950]
        mem[12'h303] = 16'h7006;  // out dev 6
        mem[12'h304] = 16'h1942;  // load [942]
        mem[12'h305] = 16'h5943;  // add [943] -> wraps
        mem[12'h306] = 16'h2951;  // store [951]
        mem[12'h307] = 16'h3011;  // in dev 011
        mem[12'h308] = 16'h7022;  // out dev 022
        mem[12'h309] = 16'h1950;  // load [950]
        mem[12'h30A] = 16'h7001;  // out dev 1
        mem[12'h30B] = 16'hF000;  // undefined
        mem[12'h940] = 16'h0003;
        mem[12'h941] = 16'h0002;
        mem[12'h942] = 16'hFFFF;
        mem[12'h943] = 16'h0003;

        fetch(12'h300, "R1");
        push_ev(0, 12'h940, 16'h0, "R3");
        fetch(12'h301, "R2");
        push_ev(0, 12'h941, 16'h0, "R5");
        fetch(12'h302, "R2");
        push_ev(1, 12'h950, 16'h0005, "R4");
        fetch(12'h303, "R2");
        push_ev(3, 12'h006, 16'h0005, "R7");
        fetch(12'h304, "R2");
        push_ev(0, 12'h942, 16'h0, "R3");
        fetch(12'h305, "R2");
        push_ev(0, 12'h943, 16'h0, "R5");
        fetch(12'h306, "R2");
        push_ev(1, 12'h951, 16'h0002, "R5");
        fetch(12'h307, "R2");
        push_ev(2, 12'h011, 16'h0, "R6");
        fetch(12'h308, "R2");
        push_ev(3, 12'h022, 16'hC011, "R6");
        fetch(12'h309, "R2");
        push_ev(0, 12'h950, 16'h0, "R9");
        fetch(12'h30A, "R2");
        push_ev(3, 12'h001, 16'h0005, "R4");
        fetch(12'h30B, "R2");

        // Reset state
        repeat (3) @(negedge clk);
        check(!(mem_re || mem_we || io_rd || io_wr), "R1", "strobes in reset",
              {28'h0, mem_re, mem_we, io_rd, io_wr}, 32'h0);
        check(halted == 1'b0, "R1", "halted in reset", {31'h0, halted}, 32'h0);
        rst_n = 1'b1;

        fork
            begin
                wait (halted === 1'b1);
            end
            begin
                repeat (3000) @(posedge clk);
                timeout = 1'b1;
            end
        join_any
        disable fork;

        if (timeout) begin
            check(1'b0, "R8", "watchdog expired", 32'h0, 32'h1);
        end else begin
            check(exp_q.size() == 0, "R2", "accesses left before halt",
                  32'(exp_q.size()), 32'h0);
            repeat (20) @(negedge clk);
            check(halted == 1'b1, "R8", "halted held", {31'h0, halted}, 32'h1);
            check(mem.exists(12'h951) && mem[12'h951] == 16'h0002, "R5",
                  "wrapped sum in memory", {16'h0, mem[12'h951]}, 32'h0002);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule